// File: doc/BRIEF.md
# Debug-Board Interrupt Expander Registers

This block sits in a small logic device on a debug board and gathers up to sixteen external interrupt sources onto one interrupt line toward a host processor. Each source passes through a two-flop synchronizer and then sets a sticky status bit. A mask register with inverted sense (a 1 blocks a source) decides which set status bits count as pending. The output line is active-low and level-sensitive: it is held low for as long as any pending source exists.

The host reaches the block over a plain synchronous 16-bit register bus with a word address, read strobe, write strobe and write data; read data is combinational from the address while the read strobe is high. Three constant identification words and a version word let software confirm the board is fitted before using it. Status bits are cleared through a separate clear register: software writes ones to clear, then writes zero to re-arm the bits. Each source has a per-bit polarity parameter so that an active-low input, such as a network controller's interrupt on bit 0, is handled without external inversion.

Top module: `dbg_irq_xpndr`

## Requirements
- R1: Reads of word 0, 1 and 2 return 0xAAAA, 0x5555 and 0xCAFE respectively.
- R2: A read of word 3 returns the VERSION parameter (default 0x0102).
- R3: After hardware reset, status (word 4) reads 0, mask (word 5) reads 0xFFFF, clear (word 6) reads 0, and irq_n is high.
- R4: A source asserted before clock edge k sets its status bit at edge k+2 (two synchronizer stages, then the status register); the bit stays set after the source deasserts.
- R5: Source n is active-low when bit n of SRC_LOW is 1 and active-high otherwise; the default SRC_LOW is 0x0001, so only source 0 is active-low.
- R6: irq_n is low exactly when some bit n has status 1 and mask 0; a mask bit of 1 disables source n.
- R7: Writing a 1 to bit n of the clear register (word 6) clears status bit n; the bit stays 0 while the clear bit is 1, even with the source active, and sets again only after the clear register is written back to 0.
- R8: Writes to words 0 to 4 and 7 change nothing, and reads of word 7 return 0; rdata is 0 when rd_en is low.
- R9: The mask and clear registers read back the last value written to them.
- R10: The sequence mask=0, clear=0xFFFF, clear=0, mask=0x001F leaves status 0, mask 0x001F and sources 0 to 4 disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC | Raw external interrupt sources, polarity per SRC_LOW |
| addr | input | AW | Word address of the register access |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid while rd_en is high |
| irq_n | output | 1 | Active-low level interrupt toward the host |

## Verification
The assertions assume the bus never raises rd_en and wr_en in the same cycle and that addresses stay within the three-bit word space; the bench drives only one strobe per cycle and draws addresses from 0 to 7. They also assume the raw sources may change at any cycle, so the sticky and clear properties are stated against the registered clear bits rather than against source timing. Random stimulus mixes mask writes, clear pulses, source toggles and reads of all eight words, while a bench model built from the requirements tracks the two-cycle synchronizer delay and the clear priority.

// File: rtl/dbg_irq_xpndr.sv
module dbg_irq_xpndr #(
  parameter int          NSRC     = 16,
  parameter int          AW       = 3,
  parameter logic [15:0] VERSION  = 16'h0102,
  parameter logic [15:0] SRC_LOW  = 16'h0001,
  parameter logic [15:0] MASK_RST = 16'hFFFF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic [AW-1:0]   addr,
  input  logic            rd_en,
  input  logic            wr_en,
  input  logic [15:0]     wdata,
  output logic [15:0]     rdata,
  output logic            irq_n
);

  localparam logic [AW-1:0] A_ID0  = AW'(0);
  localparam logic [AW-1:0] A_ID1  = AW'(1);
  localparam logic [AW-1:0] A_ID2  = AW'(2);
  localparam logic [AW-1:0] A_VER  = AW'(3);
  localparam logic [AW-1:0] A_STAT = AW'(4);
  localparam logic [AW-1:0] A_MASK = AW'(5);
  localparam logic [AW-1:0] A_CLR  = AW'(6);
  localparam int            PAD    = 16 - NSRC;

  logic [NSRC-1:0] sync1_q, sync2_q, status_q, mask_q, clr_q;
  logic [15:0]     status_w, mask_w, clr_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= src_i ^ SRC_LOW[NSRC-1:0];
      sync2_q <= sync1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q | sync2_q) & ~clr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= MASK_RST[NSRC-1:0];
      clr_q  <= '0;
    end else if (wr_en) begin
      if (addr == A_MASK) mask_q <= wdata[NSRC-1:0];
      if (addr == A_CLR)  clr_q  <= wdata[NSRC-1:0];
    end
  end

  generate
    if (PAD > 0) begin : g_pad
      assign status_w = {{PAD{1'b0}}, status_q};
      assign mask_w   = {{PAD{1'b0}}, mask_q};
      assign clr_w    = {{PAD{1'b0}}, clr_q};
    end else begin : g_full
      assign status_w = status_q;
      assign mask_w   = mask_q;
      assign clr_w    = clr_q;
    end
  endgenerate

  always_comb begin
    rdata = 16'h0000;
    if (rd_en) begin
      case (addr)
        A_ID0:   rdata = 16'hAAAA;
        A_ID1:   rdata = 16'h5555;
        A_ID2:   rdata = 16'hCAFE;
        A_VER:   rdata = VERSION;
        A_STAT:  rdata = status_w;
        A_MASK:  rdata = mask_w;
        A_CLR:   rdata = clr_w;
        default: rdata = 16'h0000;
      endcase
    end
  end

  assign irq_n = ~|(status_q & ~mask_q);

endmodule

// File: rtl/xp_chk.sv
module xp_chk #(
  parameter int NSRC = 16,
  parameter int AW   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            irq_n,
  input logic            rd_en,
  input logic [AW-1:0]   addr,
  input logic [15:0]     rdata,
  input logic [NSRC-1:0] status_q,
  input logic [NSRC-1:0] mask_q,
  input logic [NSRC-1:0] clr_q
);

  // R1
  id_word0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == AW'(0)) |-> rdata == 16'hAAAA);

  // R4
  sticky_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(status_q & ~clr_q)) == $past(status_q & ~clr_q)));

  // R7
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(clr_q)) == '0));

  // R6
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> irq_n);

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == '0) |-> irq_n);

  // R8
  no_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == 16'h0000);

endmodule

bind dbg_irq_xpndr xp_chk #(.NSRC(NSRC), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .rd_en(rd_en), .addr(addr),
  .rdata(rdata), .status_q(status_q), .mask_q(mask_q), .clr_q(clr_q)
);

// File: tb/sim_dbg_irq_xpndr.sv
module sim_dbg_irq_xpndr;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] LOWP = 16'h0001;
  localparam logic [15:0] VER  = 16'h0102;

  logic clk = 1'b0, rst_n = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [15:0] src = LOWP, wdata = '0, rdata;
  logic [2:0] addr = '0;
  logic irq_n;
  int total = 0, bad = 0;
  logic [15:0] m_s1, m_s2, m_stat, m_mask, m_clr;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_irq_xpndr u0 (.clk(clk), .rst_n(rst_n), .src_i(src), .addr(addr), .rd_en(rd_en),
                    .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .irq_n(irq_n));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_stat <= 0; m_mask <= 16'hFFFF; m_clr <= 0;
    end else begin
      m_s1 <= src ^ LOWP;
      m_s2 <= m_s1;
      m_stat <= (m_stat | m_s2) & ~m_clr;
      if (wr_en && addr == 3'd5) m_mask <= wdata;
      if (wr_en && addr == 3'd6) m_clr <= wdata;
    end
  end

  function automatic logic [15:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return 16'hAAAA;
      3'd1: return 16'h5555;
      3'd2: return 16'hCAFE;
      3'd3: return VER;
      3'd4: return m_stat;
      3'd5: return m_mask;
      3'd6: return m_clr;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic exp_irq();
    return ~|(m_stat & ~m_mask);
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [15:0] exp);
    addr = a; rd_en = 1'b1;
    #1;
    chk(tag, rdata, exp);
    rd_en = 1'b0;
    #1;
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    int seed;
    seed = $urandom(32'd1234);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R3 reset state
    rd_chk("R3 status", 3'd4, 16'h0000);
    rd_chk("R3 mask", 3'd5, 16'hFFFF);
    rd_chk("R3 clear", 3'd6, 16'h0000);
    chk("R3 irq_n", {15'd0, irq_n}, 16'h0001);
    // R1, R2, R8 read map
    rd_chk("R1 id0", 3'd0, 16'hAAAA);
    rd_chk("R1 id1", 3'd1, 16'h5555);
    rd_chk("R1 id2", 3'd2, 16'hCAFE);
    rd_chk("R2 version", 3'd3, 16'h0102);
    rd_chk("R8 unmapped", 3'd7, 16'h0000);
    #1; chk("R8 idle rdata", rdata, 16'h0000);
    // R10 init sequence with a source pending beforehand
    src = LOWP ^ 16'h0100;
    repeat (4) @(negedge clk);
    src = LOWP;
    wr(3'd5, 16'h0000);
    chk("R6 pending irq", {15'd0, irq_n}, 16'h0000);
    wr(3'd6, 16'hFFFF);
    wr(3'd6, 16'h0000);
    wr(3'd5, 16'h001F);
    rd_chk("R10 status", 3'd4, 16'h0000);
    rd_chk("R10 mask", 3'd5, 16'h001F);
    // R6 masked source 2 does not interrupt
    src = LOWP ^ 16'h0004;
    repeat (4) @(negedge clk);
    rd_chk("R6 masked status", 3'd4, 16'h0004);
    chk("R6 masked irq", {15'd0, irq_n}, 16'h0001);
    src = LOWP;
    wr(3'd6, 16'hFFFF); wr(3'd6, 16'h0000);
    wr(3'd5, 16'h0000);
    // R4 synchronizer latency on source 5
    src = LOWP ^ 16'h0020;
    @(negedge clk); rd_chk("R4 after 1 edge", 3'd4, 16'h0000);
    @(negedge clk); rd_chk("R4 after 2 edges", 3'd4, 16'h0000);
    src = LOWP;
    @(negedge clk); rd_chk("R4 after 3 edges", 3'd4, 16'h0020);
    chk("R6 irq low", {15'd0, irq_n}, 16'h0000);
    repeat (3) @(negedge clk);
    rd_chk("R4 sticky", 3'd4, 16'h0020);
    // R8 write to status and id ignored
    wr(3'd4, 16'h0000);
    wr(3'd0, 16'h1234);
    rd_chk("R8 status write", 3'd4, 16'h0020);
    rd_chk("R8 id write", 3'd0, 16'hAAAA);
    // R5 source 0 is active-low
    src = 16'h0000;
    repeat (4) @(negedge clk);
    rd_chk("R5 low active", 3'd4, 16'h0021);
    // R7 clear holds while set, re-arms after zero
    wr(3'd6, 16'h0001);
    rd_chk("R9 clear readback", 3'd6, 16'h0001);
    repeat (3) @(negedge clk);
    rd_chk("R7 held clear", 3'd4, 16'h0020);
    wr(3'd6, 16'h0000);
    @(negedge clk);
    rd_chk("R7 rearmed", 3'd4, 16'h0021);
    src = LOWP;
    wr(3'd6, 16'hFFFF); wr(3'd6, 16'h0000);
    repeat (3) @(negedge clk);
    rd_chk("R7 cleared", 3'd4, 16'h0000);
    chk("R6 irq high", {15'd0, irq_n}, 16'h0001);
    // random mix
    for (int i = 0; i < 2000; i++) begin
      int op;
      op = $urandom % 5;
      case (op)
        0: wr(3'd5, 16'($urandom));
        1: begin wr(3'd6, 16'($urandom) & 16'($urandom)); if ($urandom % 2) wr(3'd6, 16'h0000); end
        2: begin src = 16'($urandom) & 16'($urandom); @(negedge clk); end
        3: begin logic [2:0] a; a = 3'($urandom); rd_chk("R9 random read", a, exp_rd(a)); end
        default: begin wr(3'($urandom % 5), 16'($urandom)); end
      endcase
      chk("R6 random irq", {15'd0, irq_n}, {15'd0, exp_irq()});
    end
    finish_up();
  end
endmodule